// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block links two open-drain wires carrying the same serial bus line (data or clock), one on side A and one on side B. Each side presents a sampled input level and accepts a pull-down enable. When an external device pulls one side low, the repeater pulls the other side low. When that device lets go, the repeater lets go too.

The repeater records which side started the low period, and it watches only that side for the release. Because it ignores the low it creates itself, it can never hold the line low through its own drive. Each input passes through a sample filter, so a short dip near the high level does not start a drive. When a drive ends, the block can raise a short boost request on both sides to speed up the rising edge. A blanking window follows each release. At the end of that window, any side still held low by an external device becomes the new origin. Clock stretching and arbitration lows therefore carry across for as long as any device holds them.

A connect controller supplies the enable input. An accelerator-enable input decides whether boost requests are issued.

Top module: `rpt_line_repeater`

## Requirements
- R1: With `en` high and the block idle, an input that falls from high and then reads low for FILT_LEN consecutive samples drives the opposite pull-down high. The pull-down is visible FILT_LEN+1 clock edges after the input changes. A falling `a_in` sets `b_pd`, and a falling `b_in` sets `a_pd`.
- R2: A low excursion shorter than FILT_LEN samples starts no drive.
- R3: While driving, the block ignores its own driven side. It drops its pull-down FILT_LEN+1 edges after the originating side's input returns high, and it does not stay latched low afterwards.
- R4: A release is followed by a blanking window of max(BLANK_CYC, FILT_LEN+2) cycles, during which no drive starts. At the end of the window, a side whose filtered input is low becomes the new origin and the opposite side is driven. Side A is taken first when both are low. Otherwise the block goes idle.
- R5: At each release with `acc_en` high, `a_boost` and `b_boost` are both high for exactly BOOST_LEN cycles, starting in the cycle the pull-down drops. With `acc_en` low, no boost is issued, but the pull-down still drops.
- R6: If both inputs qualify as falling in the same cycle, side A is the origin and only `b_pd` is driven.
- R7: With `en` low, all four outputs are low in the same cycle and the state returns to idle. A side that is already low when `en` rises starts no drive.
- R8: `a_pd` and `b_pd` are never high together.
- R9: After the block returns to idle, a fresh falling edge starts a new drive with the R1 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Connect enable from the connect controller |
| acc_en | input | 1 | Enables boost requests on release |
| a_in | input | 1 | Sampled level of side A wire |
| b_in | input | 1 | Sampled level of side B wire |
| a_pd | output | 1 | Pull-down enable for side A |
| b_pd | output | 1 | Pull-down enable for side B |
| a_boost | output | 1 | Rising-edge boost request for side A |
| b_boost | output | 1 | Rising-edge boost request for side B |

## Verification
Two functions can fall in the same cycle. The first case is the qualification of a fall on both sides at once: the bench pulls both wires low at the same clock and expects side A to take priority. The second case is the release of the originating side while the far side is still held low by an external device. That release ends the drive and raises a boost, and the blanking window must then hand the origin to the held side. The bench judges this by expecting the boost, then a dropped pull-down, and then `a_pd` rising exactly at the end of the window.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OWN_A = 2'd1,
        ST_OWN_B = 2'd2,
        ST_BLANK = 2'd3
    } rpt_state_t;

    typedef struct packed {
        logic lvl;
        logic fall;
        logic rise;
    } edge_info_t;

    function automatic int hold_len(input int blank_cyc, input int filt_len);
        if (blank_cyc > filt_len + 1)
            return blank_cyc;
        return filt_len + 2;
    endfunction

    function automatic int cnt_width(input int n);
        if (n <= 2)
            return 1;
        return $clog2(n);
    endfunction

endpackage

// File: rtl/rpt_edge_filt.sv
module rpt_edge_filt
    import rpt_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    output edge_info_t info
);
    localparam int CW = cnt_width(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          in_q;
    logic          lvl_q;
    logic [CW-1:0] cnt_q;
    logic          differs;
    logic          flip;

    assign differs = (in_q != lvl_q);
    assign flip    = differs && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= 1'b1;
            lvl_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            in_q <= raw;
            if (flip) begin
                lvl_q <= in_q;
                cnt_q <= '0;
            end else if (differs) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        info.lvl  = lvl_q;
        info.fall = flip && !in_q;
        info.rise = flip && in_q;
    end

endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
    import rpt_pkg::*;
#(
    parameter int FILT_LEN  = 3,
    parameter int BLANK_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  edge_info_t ea,
    input  edge_info_t eb,
    output rpt_state_t st,
    output logic       rel_pulse
);
    localparam int HOLD = hold_len(BLANK_CYC, FILT_LEN);
    localparam int BW   = cnt_width(HOLD);
    localparam logic [BW-1:0] HOLD_LAST = BW'(HOLD - 1);

    rpt_state_t    st_q, st_d;
    logic [BW-1:0] bcnt_q, bcnt_d;

    assign rel_pulse = en && (((st_q == ST_OWN_A) && ea.rise) ||
                              ((st_q == ST_OWN_B) && eb.rise));

    always_comb begin
        st_d   = st_q;
        bcnt_d = bcnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ea.fall)
                    st_d = ST_OWN_A;
                else if (eb.fall)
                    st_d = ST_OWN_B;
            end
            ST_OWN_A: begin
                if (ea.rise) begin
                    st_d   = ST_BLANK;
                    bcnt_d = HOLD_LAST;
                end
            end
            ST_OWN_B: begin
                if (eb.rise) begin
                    st_d   = ST_BLANK;
                    bcnt_d = HOLD_LAST;
                end
            end
            ST_BLANK: begin
                if (bcnt_q == '0) begin
                    if (!ea.lvl)
                        st_d = ST_OWN_A;
                    else if (!eb.lvl)
                        st_d = ST_OWN_B;
                    else
                        st_d = ST_IDLE;
                end else begin
                    bcnt_d = bcnt_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (!en) begin
            st_d   = ST_IDLE;
            bcnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            bcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            bcnt_q <= bcnt_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/rpt_boost.sv
module rpt_boost #(
    parameter int BOOST_LEN = 4,
    parameter int N_SIDES   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               start,
    input  logic               acc_en,
    output logic [N_SIDES-1:0] boost
);
    localparam int CW = $clog2(BOOST_LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (start && acc_en)
            cnt_q <= CW'(BOOST_LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        assign boost[s] = en && (cnt_q != '0);
    end

endmodule

// File: rtl/rpt_line_repeater.sv
module rpt_line_repeater
    import rpt_pkg::*;
#(
    parameter int FILT_LEN  = 3,
    parameter int BLANK_CYC = 8,
    parameter int BOOST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic acc_en,
    input  logic a_in,
    input  logic b_in,
    output logic a_pd,
    output logic b_pd,
    output logic a_boost,
    output logic b_boost
);
    localparam int N_SIDES = 2;

    logic [N_SIDES-1:0] raw;
    edge_info_t         info [N_SIDES];
    rpt_state_t         st;
    logic               rel_pulse;
    logic [N_SIDES-1:0] boost;

    assign raw = {b_in, a_in};

    for (genvar s = 0; s < N_SIDES; s++) begin : g_filt
        rpt_edge_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw[s]),
            .info (info[s])
        );
    end

    rpt_ctrl #(.FILT_LEN(FILT_LEN), .BLANK_CYC(BLANK_CYC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ea        (info[0]),
        .eb        (info[1]),
        .st        (st),
        .rel_pulse (rel_pulse)
    );

    rpt_boost #(.BOOST_LEN(BOOST_LEN), .N_SIDES(N_SIDES)) u_boost (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .start  (rel_pulse),
        .acc_en (acc_en),
        .boost  (boost)
    );

    assign b_pd    = en && (st == ST_OWN_A);
    assign a_pd    = en && (st == ST_OWN_B);
    assign a_boost = boost[0];
    assign b_boost = boost[1];

endmodule

// File: rtl/rpt_chk.sv
module rpt_chk
    import rpt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       acc_en,
    input logic       a_pd,
    input logic       b_pd,
    input logic       a_boost,
    input logic       b_boost,
    input rpt_state_t st
);
    assert_never_both_R8: assert property (@(posedge clk) disable iff (rst)
        !(a_pd && b_pd));

    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == ST_IDLE));

    assert_boost_needs_acc_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(a_boost) |-> $past(acc_en));

    assert_boost_pair_R5: assert property (@(posedge clk) disable iff (rst)
        a_boost == b_boost);

    assert_boost_pd_off_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(b_boost) |-> (!a_pd && !b_pd));

endmodule

bind rpt_line_repeater rpt_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .acc_en  (acc_en),
    .a_pd    (a_pd),
    .b_pd    (b_pd),
    .a_boost (a_boost),
    .b_boost (b_boost),
    .st      (st)
);

// File: tb/tb_rpt_line_repeater.sv
module tb_rpt_line_repeater;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 3;
    localparam int BLANK = 8;
    localparam int BOOST = 4;
    localparam int LAT = FILT + 1;
    localparam int HOLD = (BLANK > FILT + 1) ? BLANK : FILT + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic acc_en = 1'b1;
    logic ext_a = 1'b0;
    logic ext_b = 1'b0;
    logic a_in, b_in, a_pd, b_pd, a_boost, b_boost;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  pa;
        logic  pb;
        logic  ba;
        logic  bb;
        string tag;
    } exp_t;

    exp_t q[$];

    assign a_in = !(a_pd || ext_a);
    assign b_in = !(b_pd || ext_b);

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rpt_line_repeater #(.FILT_LEN(FILT), .BLANK_CYC(BLANK), .BOOST_LEN(BOOST)) dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .acc_en  (acc_en),
        .a_in    (a_in),
        .b_in    (b_in),
        .a_pd    (a_pd),
        .b_pd    (b_pd),
        .a_boost (a_boost),
        .b_boost (b_boost)
    );

    task automatic expect_at(input int d, input logic pa, input logic pb,
                             input logic ba, input logic bb, input string tag);
        exp_t e;
        e.at = cyc + d; e.pa = pa; e.pb = pb; e.ba = ba; e.bb = bb; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].at == cyc) begin
                    total++;
                    if ({a_pd, b_pd, a_boost, b_boost} !== {q[i].pa, q[i].pb, q[i].ba, q[i].bb}) begin
                        bad++;
                        $display("FAIL %s cyc=%0d actual pa,pb,ba,bb=%b%b%b%b expected=%b%b%b%b",
                                 q[i].tag, cyc, a_pd, b_pd, a_boost, b_boost,
                                 q[i].pa, q[i].pb, q[i].ba, q[i].bb);
                    end
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        en  = 1'b1;
        expect_at(0, 0, 0, 0, 0, "R7 reset state");
        step(3);

        // R1: A falls, B driven after LAT edges
        ext_a = 1'b1;
        expect_at(LAT - 1, 0, 0, 0, 0, "R1 before latency");
        expect_at(LAT, 0, 1, 0, 0, "R1 a->b drive");
        step(6);

        // R3/R5: release of A, boost, no lock-up
        ext_a = 1'b0;
        expect_at(LAT - 1, 0, 1, 0, 0, "R3 still held");
        expect_at(LAT, 0, 0, 1, 1, "R3 R5 release with boost");
        expect_at(LAT + BOOST - 1, 0, 0, 1, 1, "R5 boost last cycle");
        expect_at(LAT + BOOST, 0, 0, 0, 0, "R5 boost ended");
        expect_at(LAT + HOLD, 0, 0, 0, 0, "R3 no lock-up");
        step(LAT + HOLD + 2);

        // R1: B falls, A driven
        ext_b = 1'b1;
        expect_at(LAT, 1, 0, 0, 0, "R1 b->a drive");
        step(6);

        // R5: release without accelerator
        acc_en = 1'b0;
        ext_b = 1'b0;
        expect_at(LAT, 0, 0, 0, 0, "R5 release no boost");
        expect_at(LAT + 1, 0, 0, 0, 0, "R5 no boost later");
        step(LAT + HOLD + 2);
        acc_en = 1'b1;

        // R2: short glitch rejected
        ext_a = 1'b1;
        expect_at(LAT, 0, 0, 0, 0, "R2 glitch rejected");
        expect_at(LAT + 2, 0, 0, 0, 0, "R2 glitch rejected later");
        step(FILT - 1);
        ext_a = 1'b0;
        step(10);

        // R6: simultaneous falls, A wins
        ext_a = 1'b1;
        ext_b = 1'b1;
        expect_at(LAT, 0, 1, 0, 0, "R6 A priority");
        step(6);

        // R4: A releases while B still held externally
        ext_a = 1'b0;
        expect_at(LAT, 0, 0, 1, 1, "R4 release while far side held");
        expect_at(LAT + HOLD - 1, 0, 0, 0, 0, "R4 blanking");
        expect_at(LAT + HOLD, 1, 0, 0, 0, "R4 held side becomes origin");
        step(LAT + HOLD + 2);
        ext_b = 1'b0;
        expect_at(LAT, 0, 0, 1, 1, "R4 final release");
        step(LAT + HOLD + 2);

        // R7: enable drop
        ext_a = 1'b1;
        expect_at(LAT, 0, 1, 0, 0, "R7 setup drive");
        step(6);
        en = 1'b0;
        expect_at(0, 0, 0, 0, 0, "R7 outputs off with en low");
        step(3);
        en = 1'b1;
        expect_at(LAT, 0, 0, 0, 0, "R7 held low not a fresh edge");
        expect_at(2 * LAT, 0, 0, 0, 0, "R7 held low still ignored");
        step(10);
        ext_a = 1'b0;
        step(12);

        // R9: fresh falling edge after idle
        ext_b = 1'b1;
        expect_at(LAT, 1, 0, 0, 0, "R9 fresh edge drives");
        step(6);
        ext_b = 1'b0;
        expect_at(LAT, 0, 0, 1, 1, "R9 release");
        step(LAT + HOLD + 4);

        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule